// File: doc/BRIEF.md
# Fractional L/D Clock Divider

This block derives a slower clock from an input clock by a fractional ratio. Two unsigned settings, a numerator `L` and a denominator `D`, set the output frequency to `f_in * L / D`. Each output phase, high or low, lasts about `D / (2L)` input cycles. When `D / (2L)` is a whole number, both phases are exactly that long and the duty cycle is 50%. Otherwise the phase lengths vary by one cycle, and their long-run average still gives a period of `D / L` input cycles.

The divided clock comes from a register that an accumulator toggles. The accumulator adds `2L` on every rising input edge. When the sum reaches `D`, the output phase toggles and `D` is subtracted. Some settings cannot be divided. These are `L = 0` and any setting with `2L > D`, which would be a ratio below 2. For these settings the block passes the raw input clock to the output. The selecting mux is driven only by the settings currently in use.

Register writes may change `L` and `D` at any time. The block waits for the next phase boundary before it adopts new values, so a half-finished phase is never cut short. It then restarts the accumulator from zero.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is asserted, and at the first edge after reset, the divided output is low and the accumulator is clear. The settings present during reset become the settings in use.
- R2: When `D` is a multiple of `2L`, every high and every low phase lasts exactly `D/(2L)` input cycles.
- R3: After the n-th rising input edge following the start of a setting, the divided output equals the start phase XOR bit 0 of `floor(2*L*n/D)`. The start phase is 0 after reset and after leaving pass-through, and the toggled value when the setting is adopted at a toggle edge.
- R4: Over n input cycles from reset, the number of rising output edges is `floor((floor(2*L*n/D)+1)/2)`, which gives a long-run period of `D/L` input cycles.
- R5: With `L = 0` in use, the output follows the input clock: high after a rising input edge and low after a falling input edge.
- R6: With `2L > D` in use and `L` nonzero, the output follows the input clock.
- R7: With `2L = D`, the output toggles on every rising input edge, dividing by exactly 2.
- R8: While dividing, a changed setting is adopted only at an edge where the output toggles. That edge restarts the accumulator from zero under the new setting.
- R9: While in pass-through, a changed setting is adopted at the next rising input edge. Division then starts with the output low and the accumulator clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| num_l_i | input | W | Numerator setting `L` |
| den_d_i | input | W | Denominator setting `D` |
| clk_o | output | 1 | Divided clock, or the input clock in pass-through |

## Verification
The bench builds the divider with its default 12-bit settings. It sweeps every pair with `L` from 0 to 6 and `D` from 0 to 16, which reaches all pass-through cases, the exact divide-by-2 boundary, and both whole-number and fractional phase ratios. The extreme settings `L=1, D=4095`, `L=2047, D=4095` and `L=D=4095` exercise the widest accumulator sums and the longest phases. A scripted run changes the settings in the middle of a phase and then steps into and out of pass-through. This shows that new values wait for a toggle edge when dividing, and take effect at the very next edge when in pass-through.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  typedef enum logic {
    FD_DIVIDE = 1'b0,
    FD_PASS   = 1'b1
  } fd_mode_e;

  // A setting cannot be divided when L is zero or the ratio D/L is below 2.
  function automatic fd_mode_e mode_of(input logic [31:0] l, input logic [31:0] d);
    logic [32:0] twice_l;
    twice_l = {l, 1'b0};
    if (l == 32'd0 || twice_l > {1'b0, d}) return FD_PASS;
    return FD_DIVIDE;
  endfunction

endpackage

// File: rtl/fd_setting_reg.sv
module fd_setting_reg
  import frac_div_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] l_i,
  input  logic [W-1:0] d_i,
  input  logic         boundary_i,
  output logic [W-1:0] act_l_o,
  output logic [W-1:0] act_d_o,
  output fd_mode_e     mode_o,
  output logic         chg_o
);

  logic [W-1:0] l_q;
  logic [W-1:0] d_q;

  assign chg_o   = (l_i != l_q) || (d_i != d_q);
  assign act_l_o = l_q;
  assign act_d_o = d_q;
  assign mode_o  = mode_of(32'(l_q), 32'(d_q));

  always_ff @(posedge clk_i) begin
    if (rst_i || mode_o == FD_PASS || (boundary_i && chg_o)) begin
      l_q <= l_i;
      d_q <= d_i;
    end
  end

endmodule

// File: rtl/fd_phase_acc.sv
module fd_phase_acc
  import frac_div_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] l_i,
  input  logic [W-1:0] d_i,
  input  fd_mode_e     mode_i,
  input  logic         chg_i,
  output logic         toggle_o,
  output logic         phase_o,
  output logic [W+1:0] acc_o
);

  localparam int AW = W + 2;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;
  logic          phase_q;

  assign sum      = acc_q + {1'b0, l_i, 1'b0};
  assign toggle_o = (mode_i == FD_DIVIDE) && (sum >= {2'b00, d_i});
  assign phase_o  = phase_q;
  assign acc_o    = acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || mode_i == FD_PASS) begin
      acc_q   <= '0;
      phase_q <= 1'b0;
    end else if (toggle_o) begin
      phase_q <= ~phase_q;
      acc_q   <= chg_i ? '0 : (sum - {2'b00, d_i});
    end else begin
      acc_q   <= sum;
    end
  end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] num_l_i,
  input  logic [W-1:0] den_d_i,
  output logic         clk_o
);

  logic [W-1:0] act_l;
  logic [W-1:0] act_d;
  fd_mode_e     mode;
  logic         chg;
  logic         toggle;
  logic         phase;
  logic [W+1:0] acc;

  fd_setting_reg #(.W(W)) set_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .l_i        (num_l_i),
    .d_i        (den_d_i),
    .boundary_i (toggle),
    .act_l_o    (act_l),
    .act_d_o    (act_d),
    .mode_o     (mode),
    .chg_o      (chg)
  );

  fd_phase_acc #(.W(W)) acc_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .l_i      (act_l),
    .d_i      (act_d),
    .mode_i   (mode),
    .chg_i    (chg),
    .toggle_o (toggle),
    .phase_o  (phase),
    .acc_o    (acc)
  );

  // The select comes only from registered settings, so it never changes mid-phase.
  assign clk_o = (mode == FD_PASS) ? clk_i : phase;

endmodule

// File: rtl/fd_checker.sv
module fd_checker
  import frac_div_pkg::*;
#(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_i,
  input fd_mode_e     mode,
  input logic         phase,
  input logic [W+1:0] acc,
  input logic [W-1:0] act_l,
  input logic [W-1:0] act_d
);

  // R1: the first edge after reset leaves the output low
  a_r1_low_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!phase && acc == '0));

  // R3: while dividing, the accumulator stays below the denominator
  a_r3_acc_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == FD_DIVIDE) |-> (acc < {2'b00, act_d}));

  // R8: settings in use change only on an edge that toggles the output
  a_r8_change_at_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(mode) == FD_DIVIDE && (!$stable(act_l) || !$stable(act_d)))
      |-> (phase != $past(phase)));

  // R9: an edge spent in pass-through leaves the divider cleared
  a_r9_pass_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(mode) == FD_PASS) |-> (!phase && acc == '0));

endmodule

bind frac_clk_div fd_checker #(.W(W)) chk_i (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .mode  (mode),
  .phase (phase),
  .acc   (acc),
  .act_l (act_l),
  .act_d (act_d)
);

// File: tb/frac_clk_div_tb_top.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] l_in = 12'd1;
  logic [W-1:0] d_in = 12'd4;
  logic         clk_o;

  int n_vec  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  frac_clk_div #(.W(W)) dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .num_l_i (l_in),
    .den_d_i (d_in),
    .clk_o   (clk_o)
  );

  // Arithmetic model of the expected output
  longint cur_l = 1, cur_d = 4;
  longint n = 0;
  logic   base = 1'b0;
  logic   exp_pass = 1'b0;
  logic   exp_div = 1'b0;
  int     seg = 0;      // 0: from reset, 8: adopted at toggle, 9: left pass-through
  int     rise_cnt = 0;
  logic   prev_s = 1'b0;

  function automatic logic is_pass(longint l, longint d);
    return (l == 0) || (2 * l > d);
  endfunction

  function automatic longint steps(longint l, longint d, longint k);
    return (2 * l * k) / d;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: clk_o=%0b expected %0b (L=%0d D=%0d n=%0d) at %0t",
               req, act, exp, cur_l, cur_d, n, $time);
    end
  endtask

  function automatic string tag_now();
    if (rst) return "R1";
    if (exp_pass) return (cur_l == 0) ? "R5" : "R6";
    if (seg == 8) return "R8";
    if (seg == 9) return "R9";
    if (2 * cur_l == cur_d) return "R7";
    if (cur_d % (2 * cur_l) == 0) return "R2";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cur_l = longint'(l_in); cur_d = longint'(d_in);
      n = 0; base = 1'b0; seg = 0;
      exp_pass = is_pass(cur_l, cur_d);
    end else if (exp_pass) begin
      if (longint'(l_in) != cur_l || longint'(d_in) != cur_d) seg = 9;
      cur_l = longint'(l_in); cur_d = longint'(d_in);
      n = 0; base = 1'b0;
      exp_pass = is_pass(cur_l, cur_d);
    end else begin
      n = n + 1;
      if (steps(cur_l, cur_d, n) != steps(cur_l, cur_d, n - 1) &&
          (longint'(l_in) != cur_l || longint'(d_in) != cur_d)) begin
        base = base ^ 1'(steps(cur_l, cur_d, n));
        cur_l = longint'(l_in); cur_d = longint'(d_in);
        n = 0; seg = 8;
        exp_pass = is_pass(cur_l, cur_d);
      end
    end
    exp_div = exp_pass ? 1'b0 : (base ^ 1'(steps(cur_l, cur_d, n)));
    #2;
    check(tag_now(), clk_o, exp_pass ? 1'b1 : exp_div);
  end

  always @(negedge clk) begin
    check(tag_now(), clk_o, exp_pass ? 1'b0 : exp_div);
    if (!exp_pass && !rst && clk_o && !prev_s) rise_cnt++;
    prev_s = exp_pass ? 1'b0 : clk_o;
  end

  task automatic apply_reset(int l, int d);
    @(negedge clk);
    rst = 1'b1; l_in = W'(l); d_in = W'(d);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1 rise_cnt = 0;
  endtask

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  // R4: rising-edge count over the run since reset
  task automatic check_rises();
    longint k;
    #1;
    if (!exp_pass && seg == 0) begin
      k = steps(cur_l, cur_d, n);
      n_vec++;
      if (longint'(rise_cnt) != (k + 1) / 2) begin
        n_fail++;
        $display("FAIL R4: rises=%0d expected %0d (L=%0d D=%0d n=%0d)",
                 rise_cnt, (k + 1) / 2, cur_l, cur_d, n);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    apply_reset(1, 4);
    run(40); check_rises();

    for (int l = 0; l <= 6; l++) begin
      for (int d = 0; d <= 16; d++) begin
        apply_reset(l, d);
        run(120);
        check_rises();
      end
    end

    apply_reset(1, 4095);  run(8300); check_rises();
    apply_reset(2047, 4095); run(500); check_rises();
    apply_reset(4095, 4095); run(20);

    // R8: change mid-phase, adopted at next toggle
    apply_reset(1, 10);
    run(7);
    l_in = 12'd2; d_in = 12'd6;
    run(40);
    l_in = 12'd3; d_in = 12'd14;
    run(3);
    l_in = 12'd5; d_in = 12'd11;
    run(40);
    // into pass-through at a toggle, then out again (R9)
    l_in = 12'd0;
    run(20);
    l_in = 12'd3; d_in = 12'd20;
    run(60);
    l_in = 12'd9; d_in = 12'd9;
    run(20);
    l_in = 12'd2; d_in = 12'd4;
    run(30);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule